// File: doc/BRIEF.md
# Serial-Loaded Multi-Channel Wiper Register Bank

This block is the digital control core of a six-channel, 64-step digitally adjustable resistor. A three-wire serial port writes the six wiper positions. The three wires are an enable, a serial clock and a data line. Each channel owns an 8-bit field in a 48-bit frame. The low six bits of the field give a tap position from 0 to 63. The top two bits can tell the channel to keep its present setting, so software can change one channel without knowing the settings of the others. Each wiper register drives a 6-bit output that selects a resistor tap.

When the enable input goes high, the current wiper settings are copied into the shift register. While the enable is high, every rising edge of the serial clock shifts in one bit. The last stage of the shift register drives the cascade output. That output can feed the data input of the next device in a chain, or it can be looped back to the first device, so the stored settings are read out and put back unchanged. When the enable input falls, every channel that is not marked "keep" takes its new position, and all channels change together.

The serial inputs are sampled by the block's system clock. The serial clock must therefore be slow enough that each of its levels lasts at least one system clock cycle.

Top module: `serial_wiper_bank`

## Requirements
- R1: While `ser_en` is low, changes on `ser_clk` and `ser_din` have no effect. The wiper outputs, the shift register and `casc_out` keep their values.
- R2: While `ser_en` is high, each rising edge of `ser_clk` shifts one bit into the 48-bit shift register. The first bit of a frame ends up at frame position 0, and channel k (counting from 1) occupies frame positions 8(k-1) to 8(k-1)+7, least significant bit first.
- R3: In a channel field, bits 5:0 are the tap position (0 = low end, 63 = high end). When bits 7:6 are 00, 01 or 10, the falling edge of `ser_en` copies bits 5:0 into that channel's wiper register.
- R4: When bits 7:6 of a channel field are 11, the falling edge of `ser_en` leaves that channel's wiper unchanged, whatever bits 5:0 hold.
- R5: After synchronous reset, every wiper output is 0, the shift register is 0 and `casc_out` is 0.
- R6: `casc_out` always shows the shift register's position 0, whatever the level of `ser_en`. Right after a frame starts, it shows bit 0 of channel 1.
- R7: The wiper outputs do not change while `ser_en` stays high. All channels that update do so together, on the system clock edge that first samples `ser_en` low.
- R8: On the rising edge of `ser_en`, the shift register is loaded with the current wipers, bits 7:6 of each field reading 00. Clocking 48 bits per device around a closed loop and then lowering `ser_en` leaves every wiper unchanged.
- R9: When two devices are chained (`casc_out` of the first feeds `ser_din` of the second), a 96-bit frame puts its first 48 bits into the second device and its last 48 bits into the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the serial inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ser_en | input | 1 | Serial port enable; high while a frame is in progress |
| ser_clk | input | 1 | Serial shift clock (level input, edges detected against `clk`) |
| ser_din | input | 1 | Serial data in, least significant bit first |
| casc_out | output | 1 | Cascade data out, shift register position 0 |
| wiper_pos | output | N_CH*6 | Tap positions; channel k uses bits [6(k-1)+5 : 6(k-1)] |

## Verification
The hardest state to reach is a loop readback through two chained devices. The stream coming back must be the far device's wipers followed by the near device's wipers, with zero code bits, and the frame must leave every setting as it was. To get there, the bench switches the near device's data input to the far device's cascade output and runs complete 96-bit frames. It compares every returned bit with images built from its own model. Random frames with a mix of keep and update codes come before and after the loop frame, so the settings being read back differ from channel to channel. The random frames also check the outgoing stream, which makes every write a readback as well.

// File: rtl/wbk_pkg.sv
package wbk_pkg;

    localparam int unsigned POS_W   = 6;
    localparam int unsigned CODE_W  = 2;
    localparam int unsigned FIELD_W = POS_W + CODE_W;
    localparam int unsigned DEF_CH  = 6;

    localparam logic [CODE_W-1:0] KEEP_CODE = 2'b11;
    localparam logic [CODE_W-1:0] LOAD_CODE = 2'b00;

    typedef logic [POS_W-1:0] pos_t;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        pos_t              pos;
    } field_t;

    typedef struct packed {
        logic load;
        logic shift;
        logic commit;
    } port_evt_t;

    function automatic logic is_keep(input field_t f);
        return f.code == KEEP_CODE;
    endfunction

    function automatic field_t preload_field(input pos_t p);
        field_t f;
        f.code = LOAD_CODE;
        f.pos  = p;
        return f;
    endfunction

endpackage

// File: rtl/wbk_port_ctrl.sv
module wbk_port_ctrl
    import wbk_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      ser_en,
    input  logic      ser_clk,
    output port_evt_t evt
);

    logic en_q;
    logic sclk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            sclk_q <= 1'b0;
        end else begin
            en_q   <= ser_en;
            sclk_q <= ser_clk;
        end
    end

    always_comb begin
        evt.load   = ser_en & ~en_q;
        evt.shift  = ser_en & en_q & ser_clk & ~sclk_q;
        evt.commit = ~ser_en & en_q;
    end

endmodule

// File: rtl/wbk_shifter.sv
module wbk_shifter
    import wbk_pkg::*;
#(
    parameter int unsigned N_CH = DEF_CH
) (
    input  logic                      clk,
    input  logic                      rst,
    input  port_evt_t                 evt,
    input  logic                      din,
    input  logic [N_CH*POS_W-1:0]     wiper_pos,
    output logic [N_CH*FIELD_W-1:0]   frame_q
);

    localparam int unsigned FRAME_W = N_CH * FIELD_W;

    logic [FRAME_W-1:0] preload;

    for (genvar k = 0; k < N_CH; k++) begin : g_pre
        assign preload[k*FIELD_W +: FIELD_W] = preload_field(wiper_pos[k*POS_W +: POS_W]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_q <= '0;
        end else if (evt.load) begin
            frame_q <= preload;
        end else if (evt.shift) begin
            frame_q <= {din, frame_q[FRAME_W-1:1]};
        end
    end

endmodule

// File: rtl/wbk_wiper_bank.sv
module wbk_wiper_bank
    import wbk_pkg::*;
#(
    parameter int unsigned N_CH = DEF_CH
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      commit,
    input  logic [N_CH*FIELD_W-1:0]   frame,
    output logic [N_CH*POS_W-1:0]     wiper_pos
);

    for (genvar k = 0; k < N_CH; k++) begin : g_ch
        field_t fld;
        pos_t   pos_q;

        assign fld = field_t'(frame[k*FIELD_W +: FIELD_W]);

        always_ff @(posedge clk) begin
            if (rst) begin
                pos_q <= '0;
            end else if (commit && !is_keep(fld)) begin
                pos_q <= fld.pos;
            end
        end

        assign wiper_pos[k*POS_W +: POS_W] = pos_q;
    end

endmodule

// File: rtl/serial_wiper_bank.sv
module serial_wiper_bank
    import wbk_pkg::*;
#(
    parameter int unsigned N_CH = DEF_CH
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    ser_en,
    input  logic                    ser_clk,
    input  logic                    ser_din,
    output logic                    casc_out,
    output logic [N_CH*POS_W-1:0]   wiper_pos
);

    localparam int unsigned FRAME_W = N_CH * FIELD_W;

    port_evt_t          evt;
    logic [FRAME_W-1:0] frame_q;

    wbk_port_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .ser_en  (ser_en),
        .ser_clk (ser_clk),
        .evt     (evt)
    );

    wbk_shifter #(.N_CH(N_CH)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .din       (ser_din),
        .wiper_pos (wiper_pos),
        .frame_q   (frame_q)
    );

    wbk_wiper_bank #(.N_CH(N_CH)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .commit    (evt.commit),
        .frame     (frame_q),
        .wiper_pos (wiper_pos)
    );

    assign casc_out = frame_q[0];

endmodule

// File: rtl/wbk_checker.sv
module wbk_checker
    import wbk_pkg::*;
#(
    parameter int unsigned N_CH = DEF_CH
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     ser_en,
    input logic                     casc_out,
    input logic [N_CH*POS_W-1:0]    wiper_pos,
    input logic [N_CH*FIELD_W-1:0]  frame_q,
    input port_evt_t                evt
);

    // R1
    idle_wiper_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2) && !$past(ser_en) && !$past(ser_en, 2))
        |-> $stable(wiper_pos));

    // R1
    idle_casc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(ser_en)) |-> $stable(casc_out));

    // R7
    busy_wiper_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(ser_en)) |-> $stable(wiper_pos));

    for (genvar k = 0; k < N_CH; k++) begin : g_ch
        // R3
        load_pos_chk: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $past(evt.commit)
             && $past(frame_q[k*FIELD_W+POS_W +: CODE_W]) != KEEP_CODE)
            |-> wiper_pos[k*POS_W +: POS_W] == $past(frame_q[k*FIELD_W +: POS_W]));

        // R4
        keep_pos_chk: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $past(evt.commit)
             && $past(frame_q[k*FIELD_W+POS_W +: CODE_W]) == KEEP_CODE)
            |-> $stable(wiper_pos[k*POS_W +: POS_W]));

        // R8
        preload_image_chk: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $past(evt.load))
            |-> (frame_q[k*FIELD_W+POS_W +: CODE_W] == LOAD_CODE
                 && frame_q[k*FIELD_W +: POS_W] == $past(wiper_pos[k*POS_W +: POS_W])));
    end

endmodule

bind serial_wiper_bank wbk_checker #(.N_CH(N_CH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ser_en    (ser_en),
    .casc_out  (casc_out),
    .wiper_pos (wiper_pos),
    .frame_q   (frame_q),
    .evt       (evt)
);

// File: tb/test_serial_wiper_bank.sv
module test_serial_wiper_bank;

    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 6;
    localparam int FW         = 8 * NCH;
    localparam int CHAIN_W    = 2 * FW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_en = 1'b0;
    logic ser_clk = 1'b0;
    logic tb_din = 1'b0;
    logic loop_sel = 1'b0;
    logic a_din, a_casc, b_casc;
    logic [NCH*6-1:0] a_pos, b_pos;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [5:0] mdl_a [NCH];
    logic [5:0] mdl_b [NCH];

    always #(CLK_PERIOD/2) clk = ~clk;

    assign a_din = loop_sel ? b_casc : tb_din;

    serial_wiper_bank i_serial_wiper_bank (
        .clk(clk), .rst(rst), .ser_en(ser_en), .ser_clk(ser_clk),
        .ser_din(a_din), .casc_out(a_casc), .wiper_pos(a_pos)
    );

    serial_wiper_bank i_serial_wiper_bank_far (
        .clk(clk), .rst(rst), .ser_en(ser_en), .ser_clk(ser_clk),
        .ser_din(a_casc), .casc_out(b_casc), .wiper_pos(b_pos)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [FW-1:0] image(input bit far);
        logic [FW-1:0] img = '0;
        for (int k = 0; k < NCH; k++)
            img[8*k +: 8] = {2'b00, far ? mdl_b[k] : mdl_a[k]};
        return img;
    endfunction

    task automatic check_wipers(input string tag);
        for (int k = 0; k < NCH; k++) begin
            chk(a_pos[6*k +: 6] === mdl_a[k], tag, a_pos[6*k +: 6], mdl_a[k]);
            chk(b_pos[6*k +: 6] === mdl_b[k], tag, b_pos[6*k +: 6], mdl_b[k]);
        end
    endtask

    task automatic run_frame(input logic [CHAIN_W-1:0] bits, input bit loop);
        logic [CHAIN_W-1:0] expstream;
        expstream = {image(0), image(1)};
        loop_sel = loop;
        @(negedge clk) ser_en = 1'b1;
        @(negedge clk);
        for (int i = 0; i < CHAIN_W; i++) begin
            // R2 R6 R8: stream order is far ch1 bit0 first, then near image
            chk(b_casc === expstream[i], "R2/R6/R8 readback bit", b_casc, expstream[i]);
            if (i == CHAIN_W/2)
                check_wipers("R7 wipers held mid-frame");
            tb_din = bits[i];
            ser_clk = 1'b1;
            @(negedge clk) ser_clk = 1'b0;
            @(negedge clk);
        end
        check_wipers("R7 wipers held before enable fall");
        ser_en = 1'b0;
        @(negedge clk);
        if (!loop) begin
            for (int k = 0; k < NCH; k++) begin
                if (bits[8*k+6 +: 2] != 2'b11) mdl_b[k] = bits[8*k +: 6];
                if (bits[FW+8*k+6 +: 2] != 2'b11) mdl_a[k] = bits[FW+8*k +: 6];
            end
        end
        check_wipers(loop ? "R8 loop restores wipers" : "R3/R4/R9 wipers after commit");
        loop_sel = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [CHAIN_W-1:0] fr;
        logic prev_a, prev_b;
        void'($urandom(32'd1806));
        for (int k = 0; k < NCH; k++) begin
            mdl_a[k] = '0;
            mdl_b[k] = '0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R5
        check_wipers("R5 reset wipers");
        chk(a_casc === 1'b0 && b_casc === 1'b0, "R5 reset casc", {a_casc, b_casc}, 0);

        // R3 R9: directed positions; far device gets first 48 bits
        for (int k = 0; k < NCH; k++) begin
            fr[8*k +: 8]      = {2'b00, 6'(k + 1)};
            fr[FW+8*k +: 8]   = {2'b10, 6'(63 - k)};
        end
        run_frame(fr, 0);
        chk(b_pos[5:0] === 6'd1 && a_pos[5:0] === 6'd63, "R9 chain order", {a_pos[5:0], b_pos[5:0]}, {6'd63, 6'd1});

        // R4: all keep codes
        for (int k = 0; k < 2*NCH; k++) fr[8*k +: 8] = {2'b11, 6'($urandom)};
        run_frame(fr, 0);

        // R4 R3: mixed, alternate channels keep
        for (int k = 0; k < 2*NCH; k++) fr[8*k +: 8] = {(k % 2) ? 2'b11 : 2'b01, 6'($urandom)};
        run_frame(fr, 0);

        // R8: closed loop readback
        run_frame('0, 1);

        // R1 R6: wiggle serial clock and data with enable low
        prev_a = a_casc;
        prev_b = b_casc;
        for (int i = 0; i < 12; i++) begin
            tb_din = 1'($urandom);
            ser_clk = ~ser_clk;
            @(negedge clk);
        end
        ser_clk = 1'b0;
        @(negedge clk);
        check_wipers("R1 idle port ignores clock");
        chk(a_casc === prev_a && b_casc === prev_b, "R1/R6 idle casc stable", {a_casc, b_casc}, {prev_a, prev_b});
        chk(!$isunknown({a_casc, b_casc}), "R6 casc driven", {a_casc, b_casc}, {prev_a, prev_b});

        // R2 R3 R4: random frames, each also a readback check
        for (int n = 0; n < 20; n++) begin
            for (int w = 0; w < CHAIN_W/32; w++) fr[32*w +: 32] = $urandom;
            run_frame(fr, 0);
        end

        // R8: second loop after random contents
        run_frame('0, 1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule